// File: doc/BRIEF.md
# Per-Bit Attribute Control/Status Register Bank

A small bank of 32-bit software-visible registers in which each bit follows its own access rule: read-only, write-only, plain read/write, write-1-to-clear, write-1-to-set, lockable, or write-once. The attribute layout and reset value of every register are parameters, given as per-attribute bit masks. Bits that belong to no attribute are reserved.

A host bus carries a register index, four byte enables and separate read and write strobes, so software can make byte, word or dword accesses. Internal logic uses hardware-side ports for several jobs. It drives read-only values and sets sticky status bits. It clears set-only bits and holds lockable bits. It receives a one-cycle event pulse for every write-only bit that software writes with 1.

One register, selected by parameter, holds a configuration address. It accepts only full dword accesses.

Top module: `cfgbank_top`

## Requirements
- R1: While `rst_ni` is low, each register returns to its parameter default value and every write-once bit becomes unused again. `rdata_o` and `evt_o` are also zero while reset is held.
- R2: Read data appears on `rdata_o` in the cycle after `rd_i`. Enable `be_i[k]` maps to bits 8k+7..8k (little-endian). Lanes that are not enabled read 0 and are not changed by writes. `rdata_o` is 0 in any cycle that follows one without `rd_i`.
- R3: A read-only bit reads the matching bit of `hw_val_i`. Host writes to it have no effect.
- R4: A write-only bit always reads 0. A host write with 1 in an enabled lane raises the matching `evt_o` bit for exactly the following cycle. No other write, and no other register, raises that bit.
- R5: A plain read/write bit stores the host write data of enabled lanes.
- R6: A write-1-to-clear bit clears when the host writes 1, keeps its value when the host writes 0, and sets from `hw_set_i`. If a hardware set and a host clear hit the bit in the same cycle, the bit ends up 1.
- R7: A write-1-to-set bit sets when the host writes 1, keeps its value when the host writes 0, and clears from `hw_clr_i`. If a host set and a hardware clear hit the bit in the same cycle, the bit ends up 1.
- R8: A lockable bit takes host writes only while `lock_i` for its register is low.
- R9: A write-once bit takes the first host write after reset that enables its lane, then ignores all later writes until reset. A write with its lane disabled does not use up that one write.
- R10: The configuration-address register (index `CFG_IDX`, default 0) ignores any write or read whose `be_i` is not 4'hF; such a read returns 0.
- R11: Reserved bits read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| reg_idx_i | input | IDX_W | Register index |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Registered read data |
| hw_val_i | input | NUM_REGS x 32 | Values shown by read-only bits |
| hw_set_i | input | NUM_REGS x 32 | Hardware set for write-1-to-clear bits |
| hw_clr_i | input | NUM_REGS x 32 | Hardware clear for write-1-to-set bits |
| lock_i | input | NUM_REGS | Per-register lock for lockable bits |
| evt_o | output | NUM_REGS x 32 | One-cycle pulses from write-only bits |

## Verification
A bad bit of storage shows on the next host read of its register, one cycle after `rd_i`. A bad write-once used flag shows only on the second write to that lane, because that write is then taken or dropped wrongly. A lost hardware/host collision shows as a sticky bit with the wrong value on the read that follows. A bad lane decode shows at once as event pulses, or as changed bytes, in lanes that were not enabled.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  function automatic logic [DW-1:0] lane_expand(input logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int k = 0; k < LANES; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction
endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2,
  parameter int CFG_IDX  = 0
) (
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [IDX_W-1:0]     reg_idx_i,
  input  logic [LANES-1:0]     be_i,
  output logic [NUM_REGS-1:0]  wr_sel_o,
  output logic                 rd_ok_o,
  output logic [DW-1:0]        lane_mask_o
);
  logic in_rng, partial_cfg, acc_ok;

  assign in_rng      = int'(reg_idx_i) < NUM_REGS;
  // dword-only register drops partial accesses
  assign partial_cfg = (reg_idx_i == IDX_W'(CFG_IDX)) && (be_i != '1);
  assign acc_ok      = in_rng && !partial_cfg;
  assign rd_ok_o     = rd_i && acc_ok;
  assign lane_mask_o = lane_expand(be_i);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign wr_sel_o[r] = wr_i && acc_ok && (reg_idx_i == IDX_W'(r));
  end
endmodule

// File: rtl/cfgbank_reg.sv
module cfgbank_reg
  import cfgbank_pkg::*;
#(
  parameter logic [DW-1:0] RST   = '0,
  parameter logic [DW-1:0] M_RO  = '0,
  parameter logic [DW-1:0] M_WO  = '0,
  parameter logic [DW-1:0] M_RW  = '0,
  parameter logic [DW-1:0] M_W1C = '0,
  parameter logic [DW-1:0] M_W1S = '0,
  parameter logic [DW-1:0] M_LCK = '0,
  parameter logic [DW-1:0] M_WOC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] lane_mask_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] hw_val_i,
  input  logic [DW-1:0] hw_set_i,
  input  logic [DW-1:0] hw_clr_i,
  input  logic          lock_i,
  output logic [DW-1:0] rd_val_o,
  output logic [DW-1:0] evt_o
);
  localparam logic [DW-1:0] M_PLAIN = M_RW | M_LCK | M_WOC;
  localparam logic [DW-1:0] M_STORE = M_PLAIN | M_W1C | M_W1S;

  logic [DW-1:0] q, q_n, used, evt_q;
  logic [DW-1:0] wb, wr_plain, ones, d_plain, d_w1c, d_w1s;

  assign wb       = wr_en_i ? lane_mask_i : '0;
  assign wr_plain = wb & (M_RW | (M_LCK & {DW{~lock_i}}) | (M_WOC & ~used));
  assign ones     = wb & wdata_i;

  assign d_plain = (q & ~wr_plain) | (wdata_i & wr_plain);
  // hardware set beats host clear
  assign d_w1c   = (q & ~ones) | hw_set_i;
  // host set beats hardware clear
  assign d_w1s   = (q | ones) & ~(hw_clr_i & ~ones);

  assign q_n = (d_plain & M_PLAIN) | (d_w1c & M_W1C) | (d_w1s & M_W1S);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= RST & M_STORE;
      used  <= '0;
      evt_q <= '0;
    end else begin
      q     <= q_n;
      used  <= used | (wb & M_WOC);
      evt_q <= ones & M_WO;
    end
  end

  assign rd_val_o = (q & M_STORE) | (hw_val_i & M_RO);
  assign evt_o    = evt_q;
endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_ok_i,
  input  logic [IDX_W-1:0]             reg_idx_i,
  input  logic [DW-1:0]                lane_mask_i,
  input  logic [NUM_REGS-1:0][DW-1:0]  rd_val_i,
  output logic [DW-1:0]                rdata_o
);
  logic [DW-1:0] sel, rdata_q;

  always_comb begin
    sel = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (reg_idx_i == IDX_W'(r)) sel = rd_val_i[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_ok_i) rdata_q <= sel & lane_mask_i;
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int CFG_IDX  = 0,
  parameter logic [NUM_REGS-1:0][DW-1:0] RST_VAL =
    {32'h0000_0055, 32'h1234_00A5, 32'h0000_0300, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][DW-1:0] M_RO =
    {32'h0000_FF00, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][DW-1:0] M_WO =
    {32'h0000_0000, 32'h0000_0000, 32'hFF00_0000, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][DW-1:0] M_RW =
    {32'h0000_00FF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFC},
  parameter logic [NUM_REGS-1:0][DW-1:0] M_W1C =
    {32'hF000_0000, 32'h0000_0000, 32'h0000_FF00, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][DW-1:0] M_W1S =
    {32'h0000_0000, 32'h0000_0000, 32'h00FF_0000, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][DW-1:0] M_LCK =
    {32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][DW-1:0] M_WOC =
    {32'h0000_0000, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_0000},
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [IDX_W-1:0]             reg_idx_i,
  input  logic [LANES-1:0]             be_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [DW-1:0]                rdata_o,
  input  logic [NUM_REGS-1:0][DW-1:0]  hw_val_i,
  input  logic [NUM_REGS-1:0][DW-1:0]  hw_set_i,
  input  logic [NUM_REGS-1:0][DW-1:0]  hw_clr_i,
  input  logic [NUM_REGS-1:0]          lock_i,
  output logic [NUM_REGS-1:0][DW-1:0]  evt_o
);
  logic [NUM_REGS-1:0]         wr_sel;
  logic                        rd_ok;
  logic [DW-1:0]               lane_mask;
  logic [NUM_REGS-1:0][DW-1:0] rd_val;

  cfgbank_decode #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CFG_IDX(CFG_IDX)
  ) u_decode (
    .wr_i(wr_i), .rd_i(rd_i), .reg_idx_i(reg_idx_i), .be_i(be_i),
    .wr_sel_o(wr_sel), .rd_ok_o(rd_ok), .lane_mask_o(lane_mask)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    cfgbank_reg #(
      .RST(RST_VAL[r]), .M_RO(M_RO[r]), .M_WO(M_WO[r]), .M_RW(M_RW[r]),
      .M_W1C(M_W1C[r]), .M_W1S(M_W1S[r]), .M_LCK(M_LCK[r]), .M_WOC(M_WOC[r])
    ) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_sel[r]),
      .lane_mask_i(lane_mask), .wdata_i(wdata_i),
      .hw_val_i(hw_val_i[r]), .hw_set_i(hw_set_i[r]), .hw_clr_i(hw_clr_i[r]),
      .lock_i(lock_i[r]), .rd_val_o(rd_val[r]), .evt_o(evt_o[r])
    );
  end

  cfgbank_rdmux #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rdmux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_ok_i(rd_ok), .reg_idx_i(reg_idx_i),
    .lane_mask_i(lane_mask), .rd_val_i(rd_val), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int CFG_IDX  = 0,
  parameter int IDX_W    = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_i,
  input logic                         rd_i,
  input logic [IDX_W-1:0]             reg_idx_i,
  input logic [LANES-1:0]             be_i,
  input logic [DW-1:0]                wdata_i,
  input logic [DW-1:0]                rdata_o,
  input logic [NUM_REGS-1:0][DW-1:0]  evt_o
);
  // R2
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));

  // R2
  rdata_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> ((rdata_o & ~lane_expand($past(be_i))) == '0));

  // R4
  evt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (evt_o == '0));

  // R10
  cfg_partial_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (reg_idx_i == IDX_W'(CFG_IDX)) && (be_i != '1)) |=> (rdata_o == '0));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_evt
    // R4
    evt_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && (reg_idx_i != IDX_W'(r))) |=> (evt_o[r] == '0));

    // R4
    evt_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> ((evt_o[r] & ~($past(wdata_i) & lane_expand($past(be_i)))) == '0));
  end
endmodule

bind cfgbank_top cfgbank_chk #(
  .NUM_REGS(NUM_REGS), .CFG_IDX(CFG_IDX), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
  .reg_idx_i(reg_idx_i), .be_i(be_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .evt_o(evt_o)
);

// File: tb/tb_cfgbank_top.sv
`timescale 1ns/1ps
module tb_cfgbank_top;
  localparam int NR = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0]        reg_idx_i = '0;
  logic [3:0]        be_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NR-1:0][31:0] hw_val_i = '0, hw_set_i = '0, hw_clr_i = '0, evt_o;
  logic [NR-1:0]     lock_i = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd_v;
  logic [NR-1:0][31:0] evt_v;

  cfgbank_top dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic host_wr(input int idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; reg_idx_i = 2'(idx); be_i = be; wdata_i = d;
    @(negedge clk_i);
    evt_v = evt_o;
    wr_i = 1'b0; be_i = '0; wdata_i = '0;
  endtask

  task automatic host_rd(input int idx, input logic [3:0] be);
    @(negedge clk_i);
    rd_i = 1'b1; reg_idx_i = 2'(idx); be_i = be;
    @(negedge clk_i);
    rd_v = rdata_o;
    rd_i = 1'b0; be_i = '0;
  endtask

  task automatic t_reset();
    check("R1 rdata in reset", rdata_o, 0);
    check("R1 evt in reset", evt_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    host_rd(0, 4'hF); check("R1 reg0 default", rd_v, 32'h0);
    host_rd(1, 4'hF); check("R1 R3 reg1 default", rd_v, 32'h0000_03A5);
    host_rd(2, 4'hF); check("R1 reg2 default", rd_v, 32'h1234_00A5);
    host_rd(3, 4'hF); check("R1 reg3 default", rd_v, 32'h0000_3C55);
  endtask

  task automatic t_cfg();
    host_wr(0, 4'hF, 32'hDEAD_BEEF);
    host_rd(0, 4'hF); check("R5 R11 cfg dword write", rd_v, 32'hDEAD_BEEC);
    host_wr(0, 4'h3, 32'h0);
    host_rd(0, 4'hF); check("R10 cfg partial write ignored", rd_v, 32'hDEAD_BEEC);
    host_rd(0, 4'h3); check("R10 cfg partial read zero", rd_v, 32'h0);
  endtask

  task automatic t_lanes();
    host_wr(3, 4'h1, 32'hFFFF_FFAA);
    host_rd(3, 4'hF); check("R2 lane0 write only", rd_v, 32'h0000_3CAA);
    host_rd(3, 4'h2); check("R2 lane1 read only", rd_v, 32'h0000_3C00);
    host_wr(3, 4'hF, 32'hFFFF_FFFF);
    host_rd(3, 4'hF); check("R11 R6 reserved zero", rd_v, 32'h0000_3CFF);
    @(negedge clk_i); check("R2 idle rdata", rdata_o, 0);
  endtask

  task automatic t_ro();
    host_wr(1, 4'h1, 32'h0000_00FF);
    host_rd(1, 4'hF); check("R3 write ignored", rd_v, 32'h0000_03A5);
    hw_val_i[1] = 32'h0000_005A;
    host_rd(1, 4'hF); check("R3 follows hw", rd_v, 32'h0000_035A);
  endtask

  task automatic t_w1c();
    host_wr(1, 4'h2, 32'h0000_0100);
    host_rd(1, 4'hF); check("R6 write1 clears", rd_v, 32'h0000_025A);
    host_wr(1, 4'h2, 32'h0);
    host_rd(1, 4'hF); check("R6 write0 keeps", rd_v, 32'h0000_025A);
    @(negedge clk_i); hw_set_i[1] = 32'h0000_1000;
    @(negedge clk_i); hw_set_i[1] = '0;
    host_rd(1, 4'hF); check("R6 hw set", rd_v, 32'h0000_125A);
    @(negedge clk_i);
    hw_set_i[1] = 32'h0000_0200;
    wr_i = 1'b1; reg_idx_i = 2'd1; be_i = 4'h2; wdata_i = 32'h0000_0200;
    @(negedge clk_i);
    hw_set_i[1] = '0; wr_i = 1'b0; be_i = '0; wdata_i = '0;
    host_rd(1, 4'hF); check("R6 hw set wins", rd_v, 32'h0000_125A);
    host_wr(1, 4'h2, 32'h0000_0200);
    host_rd(1, 4'hF); check("R6 clear bit9", rd_v, 32'h0000_105A);
  endtask

  task automatic t_w1s();
    host_wr(1, 4'h4, 32'h0001_0000);
    host_rd(1, 4'hF); check("R7 write1 sets", rd_v, 32'h0001_105A);
    host_wr(1, 4'h4, 32'h0);
    host_rd(1, 4'hF); check("R7 write0 keeps", rd_v, 32'h0001_105A);
    @(negedge clk_i); hw_clr_i[1] = 32'h0001_0000;
    @(negedge clk_i); hw_clr_i[1] = '0;
    host_rd(1, 4'hF); check("R7 hw clear", rd_v, 32'h0000_105A);
    @(negedge clk_i);
    hw_clr_i[1] = 32'h0002_0000;
    wr_i = 1'b1; reg_idx_i = 2'd1; be_i = 4'h4; wdata_i = 32'h0002_0000;
    @(negedge clk_i);
    hw_clr_i[1] = '0; wr_i = 1'b0; be_i = '0; wdata_i = '0;
    host_rd(1, 4'hF); check("R7 host set wins", rd_v, 32'h0002_105A);
  endtask

  task automatic t_wo();
    host_wr(1, 4'h8, 32'h8100_0000);
    check("R4 pulse", evt_v[1], 32'h8100_0000);
    check("R4 other regs quiet", {evt_v[3], evt_v[2], evt_v[0]}, 0);
    @(negedge clk_i); check("R4 one cycle", evt_o, 0);
    host_wr(1, 4'h7, 32'hFF00_0000);
    check("R4 disabled lane no pulse", evt_v, 0);
    host_rd(1, 4'hF); check("R4 reads zero", rd_v, 32'h0002_105A);
  endtask

  task automatic t_lock();
    lock_i[2] = 1'b1;
    host_wr(2, 4'h3, 32'h0000_FFFF);
    host_rd(2, 4'hF); check("R8 locked", rd_v, 32'h1234_00A5);
    lock_i[2] = 1'b0;
    host_wr(2, 4'h3, 32'h0000_FFFF);
    host_rd(2, 4'hF); check("R8 unlocked", rd_v, 32'h1234_FFFF);
  endtask

  task automatic t_once();
    host_wr(2, 4'h4, 32'h00AB_0000);
    host_rd(2, 4'hF); check("R9 first write", rd_v, 32'h12AB_FFFF);
    host_wr(2, 4'hC, 32'hCDEF_0000);
    host_rd(2, 4'hF); check("R9 lane kept unused", rd_v, 32'hCDAB_FFFF);
    host_wr(2, 4'h8, 32'h7700_0000);
    host_rd(2, 4'hF); check("R9 second write ignored", rd_v, 32'hCDAB_FFFF);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    host_rd(2, 4'hF); check("R1 reg2 after reset", rd_v, 32'h1234_00A5);
    host_rd(0, 4'hF); check("R1 reg0 after reset", rd_v, 32'h0);
    host_wr(2, 4'hF, 32'h9999_9999);
    host_rd(2, 4'hF); check("R1 R9 used flags cleared", rd_v, 32'h9999_9999);
  endtask

  initial begin
    hw_val_i[1] = 32'h0000_00A5;
    hw_val_i[3] = 32'h0000_3C00;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_cfg();
    t_lanes();
    t_ro();
    t_w1c();
    t_w1s();
    t_wo();
    t_lock();
    t_once();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule